// File: doc/BRIEF.md
# PLL Integer Divider Search Engine

This block searches for integer PLL settings that produce a requested output frequency from a given reference frequency. Both frequencies are given in hertz. The settings it returns are a post-shift `s`, a pre-divider `p` and a feedback multiplier `m`. They must satisfy two conditions: the VCO frequency, `fout << s`, lies in its legal window, and `floor(m * fin / p)` equals that VCO frequency exactly.

A request is started with a one-cycle `start` strobe. The engine latches both frequencies and screens out degenerate or out-of-range requests. It then walks its candidate loops, evaluating one `(s, p, m)` triple per evaluation step. It finishes with a single-cycle `done` pulse and a `found` flag. The result stays on the outputs until the next accepted start, so a slow consumer can read it at any time.

The quotient `m * fin / p` is formed by a bank of constant dividers, one for each legal `p`. A multiplexer picks the bank output that matches the current `p`. A parameter can insert a register stage in front of the divider bank. With that stage, each evaluation step takes two cycles.

Top module: `pll_param_search`

## Requirements
- R1: A request whose reference frequency is 0, whose output frequency is 0, or whose output frequency equals the reference frequency ends with `done` and `found` = 0, without searching.
- R2: A request whose output frequency is below 37 000 000 Hz or above 4 500 000 000 Hz ends with `found` = 0. Both limits themselves are accepted.
- R3: A request in which either frequency is not a whole multiple of 1 000 000 Hz ends with `found` = 0.
- R4: `s` is tried from 0 to 6, smallest first. An `s` is used only when `fout << s` lies between 2 250 000 000 Hz and 4 500 000 000 Hz, both ends included. When two values of `s` would both give a match, the smaller `s` wins.
- R5: Within an `s`, `p` is tried from 2 up to 4. Within a `p`, `m` is tried from 64 up to 1023. The first matching triple in that order is returned. A match that needs `m` outside 64..1023 is never returned.
- R6: A triple matches when `floor(m * fin / p)` equals `fout << s`. On a match, `s_out`, `p_out` and `m_out` carry `s`, `p` and `m` as plain binary numbers.
- R7: When no triple matches, `done` still pulses, `found` is 0, and `s_out`, `p_out` and `m_out` are 0.
- R8: `busy` is 1 from the cycle after an accepted `start` until the result is ready. `done` is 1 for exactly one cycle. `busy` and `done` are never 1 together.
- R9: `start` is ignored while `busy` is 1, including any change to the frequency inputs. `found`, `s_out`, `p_out` and `m_out` hold their values until the next accepted `start`.
- R10: After reset, `busy`, `done`, `found`, `s_out`, `p_out` and `m_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a search; accepted only when `busy` is 0 |
| fin_hz | input | FREQ_W (40) | Reference frequency in Hz, sampled on an accepted start |
| fout_hz | input | FREQ_W (40) | Requested output frequency in Hz, sampled on an accepted start |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| found | output | 1 | 1 when a matching triple was found |
| s_out | output | clog2(S_MAX+1) (3) | Post-shift of the result |
| p_out | output | clog2(P_MAX+1) (3) | Pre-divider of the result |
| m_out | output | clog2(M_MAX+1) (10) | Feedback multiplier of the result |

## Verification
The bound checker watches several properties on every cycle: the one-cycle `done` pulse and its exclusion with `busy`, the holding of the result while idle, the zeroed outputs on a miss, and the freezing of the latched request while busy. Each time a match is reported, it also recomputes the match equation, the VCO window, the candidate ranges and the request screening. The checker cannot show that the reported triple is the first one in loop order, or that a miss really has no solution. Only the bench's known-answer requests can show that. They include requests where two values of `s`, two values of `p`, or an out-of-range `m` compete, and they also exercise a `start` issued in the middle of a running search.

// File: rtl/pllsrch_pkg.sv
`timescale 1ns/1ps
package pllsrch_pkg;

   // search sequencer states
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_CHECK = 3'd1,
      ST_SHIFT = 3'd2,
      ST_SCAN  = 3'd3,
      ST_DONE  = 3'd4
   } srch_state_e;

   // bits needed to hold a value 0..max
   function automatic int bits_for(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/pllsrch_req_check.sv
`timescale 1ns/1ps
// Screens a latched request: degenerate values, output range, whole-step granularity.
module pllsrch_req_check #(
   parameter int              FREQ_W      = 40,
   parameter longint unsigned STEP_HZ     = 64'd1_000_000,
   parameter longint unsigned FOUT_MIN_HZ = 64'd37_000_000,
   parameter longint unsigned FOUT_MAX_HZ = 64'd4_500_000_000
) (
   input  logic [FREQ_W-1:0] fin,
   input  logic [FREQ_W-1:0] fout,
   output logic              ok
);

   logic [63:0] fin_w;
   logic [63:0] fout_w;
   logic        non_zero;
   logic        not_same;
   logic        in_range;
   logic        whole_step;

   assign fin_w      = 64'(fin);
   assign fout_w     = 64'(fout);
   assign non_zero   = (fin_w != 64'd0) && (fout_w != 64'd0);
   assign not_same   = (fin_w != fout_w);
   assign in_range   = (fout_w >= FOUT_MIN_HZ) && (fout_w <= FOUT_MAX_HZ);
   assign whole_step = ((fin_w % STEP_HZ) == 64'd0) && ((fout_w % STEP_HZ) == 64'd0);
   assign ok         = non_zero && not_same && in_range && whole_step;

endmodule

// File: rtl/pllsrch_qmux.sv
`timescale 1ns/1ps
// Bank of constant dividers, one per legal pre-divider, selected by p.
module pllsrch_qmux #(
   parameter int PROD_W = 64,
   parameter int P_W    = 3,
   parameter int P_MIN  = 2,
   parameter int P_MAX  = 4
) (
   input  logic [PROD_W-1:0] prod,
   input  logic [P_W-1:0]    p,
   output logic [PROD_W-1:0] q
);

   localparam int P_CNT = P_MAX - P_MIN + 1;

   logic [PROD_W-1:0] quo [P_CNT];

   for (genvar gi = 0; gi < P_CNT; gi++) begin : g_div
      assign quo[gi] = prod / PROD_W'(P_MIN + gi);
   end

   always_comb begin
      q = '0;
      for (int i = 0; i < P_CNT; i++) begin
         if (p == P_W'(P_MIN + i)) q = quo[i];
      end
   end

endmodule

// File: rtl/pllsrch_ctrl.sv
`timescale 1ns/1ps
// Sequencer: request latch, nested s/p/m loops, window filter, result registers.
module pllsrch_ctrl
   import pllsrch_pkg::*;
#(
   parameter int              FREQ_W      = 40,
   parameter int              PROD_W      = 64,
   parameter int              S_MAX       = 6,
   parameter int              P_MIN       = 2,
   parameter int              P_MAX       = 4,
   parameter int              M_MIN       = 64,
   parameter int              M_MAX       = 1023,
   parameter bit              EARLY_EXIT  = 1'b1,
   parameter longint unsigned VCO_MIN_HZ  = 64'd2_250_000_000,
   parameter longint unsigned VCO_MAX_HZ  = 64'd4_500_000_000,
   parameter int              S_W         = 3,
   parameter int              P_W         = 3,
   parameter int              M_W         = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [FREQ_W-1:0] fin_hz,
   input  logic [FREQ_W-1:0] fout_hz,
   input  logic              req_ok,
   output logic [FREQ_W-1:0] lat_fin,
   output logic [FREQ_W-1:0] lat_fout,
   output logic              cand_req,
   output logic [M_W-1:0]    cand_m,
   output logic [P_W-1:0]    cand_p,
   input  logic              q_vld,
   input  logic [PROD_W-1:0] q,
   output logic              busy,
   output logic              done,
   output logic              found,
   output logic [S_W-1:0]    s_out,
   output logic [P_W-1:0]    p_out,
   output logic [M_W-1:0]    m_out
);

   localparam int VCO_W = FREQ_W + S_MAX;

   srch_state_e       state_q;
   logic [S_W-1:0]    s_q;
   logic [P_W-1:0]    p_q;
   logic [M_W-1:0]    m_q;
   logic              pend_q;
   logic [VCO_W-1:0]  vco;
   logic              in_win;
   logic              hit;
   logic              over;
   logic              last_s;
   logic              last_p;
   logic              last_m;
   logic              accept;

   assign vco    = VCO_W'(lat_fout) << s_q;
   assign in_win = (64'(vco) >= VCO_MIN_HZ) && (64'(vco) <= VCO_MAX_HZ);
   assign hit    = (q == PROD_W'(vco));
   assign over   = EARLY_EXIT && (q > PROD_W'(vco));
   assign last_s = (s_q == S_W'(S_MAX));
   assign last_p = (p_q == P_W'(P_MAX));
   assign last_m = (m_q == M_W'(M_MAX));
   assign accept = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));

   assign cand_req = (state_q == ST_SCAN) && !pend_q;
   assign cand_m   = m_q;
   assign cand_p   = p_q;
   assign busy     = (state_q == ST_CHECK) || (state_q == ST_SHIFT) || (state_q == ST_SCAN);
   assign done     = (state_q == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         s_q      <= '0;
         p_q      <= '0;
         m_q      <= '0;
         pend_q   <= 1'b0;
         lat_fin  <= '0;
         lat_fout <= '0;
         found    <= 1'b0;
         s_out    <= '0;
         p_out    <= '0;
         m_out    <= '0;
      end else begin
         // divider handshake: waiting for a registered quotient
         if (q_vld)         pend_q <= 1'b0;
         else if (cand_req) pend_q <= 1'b1;

         case (state_q)
            ST_IDLE, ST_DONE: begin
               if (accept) begin
                  lat_fin  <= fin_hz;
                  lat_fout <= fout_hz;
                  found    <= 1'b0;
                  s_out    <= '0;
                  p_out    <= '0;
                  m_out    <= '0;
                  state_q  <= ST_CHECK;
               end else begin
                  state_q  <= ST_IDLE;
               end
            end
            ST_CHECK: begin
               s_q     <= '0;
               state_q <= req_ok ? ST_SHIFT : ST_DONE;
            end
            ST_SHIFT: begin
               if (in_win) begin
                  p_q     <= P_W'(P_MIN);
                  m_q     <= M_W'(M_MIN);
                  pend_q  <= 1'b0;
                  state_q <= ST_SCAN;
               end else if (last_s) begin
                  state_q <= ST_DONE;
               end else begin
                  s_q     <= s_q + S_W'(1);
               end
            end
            ST_SCAN: begin
               if (q_vld) begin
                  if (hit) begin
                     found   <= 1'b1;
                     s_out   <= s_q;
                     p_out   <= p_q;
                     m_out   <= m_q;
                     state_q <= ST_DONE;
                  end else if (over || last_m) begin
                     if (!last_p) begin
                        p_q <= p_q + P_W'(1);
                        m_q <= M_W'(M_MIN);
                     end else if (last_s) begin
                        state_q <= ST_DONE;
                     end else begin
                        s_q     <= s_q + S_W'(1);
                        state_q <= ST_SHIFT;
                     end
                  end else begin
                     m_q <= m_q + M_W'(1);
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pll_param_search.sv
`timescale 1ns/1ps
// Integer PLL setting search engine: one (s, p, m) candidate per evaluation step.
module pll_param_search
   import pllsrch_pkg::*;
#(
   parameter int              FREQ_W      = 40,
   parameter int              PROD_W      = 64,
   parameter int              S_MAX       = 6,
   parameter int              P_MIN       = 2,
   parameter int              P_MAX       = 4,
   parameter int              M_MIN       = 64,
   parameter int              M_MAX       = 1023,
   parameter bit              DIV_REG     = 1'b0,
   parameter bit              EARLY_EXIT  = 1'b1,
   parameter longint unsigned STEP_HZ     = 64'd1_000_000,
   parameter longint unsigned FOUT_MIN_HZ = 64'd37_000_000,
   parameter longint unsigned FOUT_MAX_HZ = 64'd4_500_000_000,
   parameter longint unsigned VCO_MIN_HZ  = 64'd2_250_000_000,
   parameter longint unsigned VCO_MAX_HZ  = 64'd4_500_000_000,
   localparam int             S_W         = bits_for(S_MAX),
   localparam int             P_W         = bits_for(P_MAX),
   localparam int             M_W         = bits_for(M_MAX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [FREQ_W-1:0] fin_hz,
   input  logic [FREQ_W-1:0] fout_hz,
   output logic              busy,
   output logic              done,
   output logic              found,
   output logic [S_W-1:0]    s_out,
   output logic [P_W-1:0]    p_out,
   output logic [M_W-1:0]    m_out
);

   // elaboration-time parameter screening
   if (P_MIN < 1 || P_MAX < P_MIN) begin : g_bad_p
      $error("pll_param_search: pre-divider range is empty or includes zero");
   end
   if (M_MIN < 1 || M_MAX < M_MIN) begin : g_bad_m
      $error("pll_param_search: multiplier range is empty or includes zero");
   end
   if (FREQ_W + M_W > PROD_W || PROD_W > 64) begin : g_bad_prod
      $error("pll_param_search: product width too small or above 64");
   end
   if (FREQ_W + S_MAX > PROD_W) begin : g_bad_vco
      $error("pll_param_search: shifted output does not fit the product width");
   end
   if (STEP_HZ == 64'd0 || VCO_MAX_HZ < VCO_MIN_HZ || FOUT_MAX_HZ < FOUT_MIN_HZ) begin : g_bad_f
      $error("pll_param_search: frequency limits are inconsistent");
   end

   logic [FREQ_W-1:0] lat_fin;
   logic [FREQ_W-1:0] lat_fout;
   logic              req_ok;
   logic              cand_req;
   logic [M_W-1:0]    cand_m;
   logic [P_W-1:0]    cand_p;
   logic [PROD_W-1:0] prod_c;
   logic [PROD_W-1:0] div_prod;
   logic [P_W-1:0]    div_p;
   logic              q_vld;
   logic [PROD_W-1:0] q;

   pllsrch_req_check #(
      .FREQ_W      (FREQ_W),
      .STEP_HZ     (STEP_HZ),
      .FOUT_MIN_HZ (FOUT_MIN_HZ),
      .FOUT_MAX_HZ (FOUT_MAX_HZ)
   ) u_req (
      .fin  (lat_fin),
      .fout (lat_fout),
      .ok   (req_ok)
   );

   assign prod_c = PROD_W'(cand_m) * PROD_W'(lat_fin);

   if (DIV_REG) begin : g_div_reg
      logic [PROD_W-1:0] prod_r;
      logic [P_W-1:0]    p_r;
      logic              vld_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prod_r <= '0;
            p_r    <= '0;
            vld_r  <= 1'b0;
         end else begin
            vld_r <= cand_req;
            if (cand_req) begin
               prod_r <= prod_c;
               p_r    <= cand_p;
            end
         end
      end
      assign div_prod = prod_r;
      assign div_p    = p_r;
      assign q_vld    = vld_r;
   end else begin : g_div_comb
      assign div_prod = prod_c;
      assign div_p    = cand_p;
      assign q_vld    = cand_req;
   end

   pllsrch_qmux #(
      .PROD_W (PROD_W),
      .P_W    (P_W),
      .P_MIN  (P_MIN),
      .P_MAX  (P_MAX)
   ) u_qmux (
      .prod (div_prod),
      .p    (div_p),
      .q    (q)
   );

   pllsrch_ctrl #(
      .FREQ_W     (FREQ_W),
      .PROD_W     (PROD_W),
      .S_MAX      (S_MAX),
      .P_MIN      (P_MIN),
      .P_MAX      (P_MAX),
      .M_MIN      (M_MIN),
      .M_MAX      (M_MAX),
      .EARLY_EXIT (EARLY_EXIT),
      .VCO_MIN_HZ (VCO_MIN_HZ),
      .VCO_MAX_HZ (VCO_MAX_HZ),
      .S_W        (S_W),
      .P_W        (P_W),
      .M_W        (M_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .fin_hz   (fin_hz),
      .fout_hz  (fout_hz),
      .req_ok   (req_ok),
      .lat_fin  (lat_fin),
      .lat_fout (lat_fout),
      .cand_req (cand_req),
      .cand_m   (cand_m),
      .cand_p   (cand_p),
      .q_vld    (q_vld),
      .q        (q),
      .busy     (busy),
      .done     (done),
      .found    (found),
      .s_out    (s_out),
      .p_out    (p_out),
      .m_out    (m_out)
   );

endmodule

// File: rtl/pll_param_search_chk.sv
`timescale 1ns/1ps
// Protocol and result checker, bound to pll_param_search.
module pll_param_search_chk #(
   parameter int              FREQ_W      = 40,
   parameter int              S_MAX       = 6,
   parameter int              P_MIN       = 2,
   parameter int              P_MAX       = 4,
   parameter int              M_MIN       = 64,
   parameter int              M_MAX       = 1023,
   parameter longint unsigned STEP_HZ     = 64'd1_000_000,
   parameter longint unsigned FOUT_MIN_HZ = 64'd37_000_000,
   parameter longint unsigned FOUT_MAX_HZ = 64'd4_500_000_000,
   parameter longint unsigned VCO_MIN_HZ  = 64'd2_250_000_000,
   parameter longint unsigned VCO_MAX_HZ  = 64'd4_500_000_000,
   parameter int              S_W         = 3,
   parameter int              P_W         = 3,
   parameter int              M_W         = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              found,
   input logic [S_W-1:0]    s_out,
   input logic [P_W-1:0]    p_out,
   input logic [M_W-1:0]    m_out,
   input logic [FREQ_W-1:0] fin_lat,
   input logic [FREQ_W-1:0] fout_lat
);

   logic [63:0] vco_w;
   logic [63:0] quo_w;

   assign vco_w = 64'(fout_lat) << s_out;
   assign quo_w = (p_out == '0) ? 64'd0 : (64'(m_out) * 64'(fin_lat)) / 64'(p_out);

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   // R9
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !busy) |=> $stable({found, s_out, p_out, m_out}));

   // R9
   request_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(fin_lat) && $stable(fout_lat)));

   // R7
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !found) |-> (s_out == '0 && p_out == '0 && m_out == '0));

   // R5
   cand_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && found) |-> (p_out >= P_W'(P_MIN) && p_out <= P_W'(P_MAX) &&
                           m_out >= M_W'(M_MIN) && m_out <= M_W'(M_MAX) &&
                           s_out <= S_W'(S_MAX)));

   // R4
   vco_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && found) |-> (vco_w >= VCO_MIN_HZ && vco_w <= VCO_MAX_HZ));

   // R6
   exact_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && found) |-> (quo_w == vco_w));

   // R1
   degenerate_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && found) |-> (fin_lat != '0 && fout_lat != '0 && fin_lat != fout_lat));

   // R2
   fout_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && found) |-> (64'(fout_lat) >= FOUT_MIN_HZ && 64'(fout_lat) <= FOUT_MAX_HZ));

   // R3
   whole_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && found) |-> ((64'(fin_lat) % STEP_HZ) == 64'd0 && (64'(fout_lat) % STEP_HZ) == 64'd0));

endmodule

bind pll_param_search pll_param_search_chk #(
   .FREQ_W      (FREQ_W),
   .S_MAX       (S_MAX),
   .P_MIN       (P_MIN),
   .P_MAX       (P_MAX),
   .M_MIN       (M_MIN),
   .M_MAX       (M_MAX),
   .STEP_HZ     (STEP_HZ),
   .FOUT_MIN_HZ (FOUT_MIN_HZ),
   .FOUT_MAX_HZ (FOUT_MAX_HZ),
   .VCO_MIN_HZ  (VCO_MIN_HZ),
   .VCO_MAX_HZ  (VCO_MAX_HZ),
   .S_W         (S_W),
   .P_W         (P_W),
   .M_W         (M_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .found    (found),
   .s_out    (s_out),
   .p_out    (p_out),
   .m_out    (m_out),
   .fin_lat  (lat_fin),
   .fout_lat (lat_fout)
);

// File: tb/pll_param_search_bench.sv
`timescale 1ns/1ps
module pll_param_search_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [39:0] fin_hz = '0;
   logic [39:0] fout_hz = '0;
   logic        busy;
   logic        done;
   logic        found;
   logic [2:0]  s_out;
   logic [2:0]  p_out;
   logic [9:0]  m_out;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;   // 250 MHz

   pll_param_search u_pll_param_search (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .fin_hz  (fin_hz),
      .fout_hz (fout_hz),
      .busy    (busy),
      .done    (done),
      .found   (found),
      .s_out   (s_out),
      .p_out   (p_out),
      .m_out   (m_out)
   );

   localparam int NV = 15;
   // fin, fout, expected found/s/p/m, requirement number
   localparam longint unsigned V_FIN [NV] = '{
      64'd24_000_000, 64'd24_000_000, 64'd24_000_000, 64'd24_000_000, 64'd24_000_000,
      64'd24_000_000, 64'd100_000_000, 64'd0,         64'd24_000_000, 64'd24_000_000,
      64'd24_500_000, 64'd24_000_000, 64'd1_000_000,  64'd100_000_000, 64'd24_000_000};
   localparam longint unsigned V_FOUT [NV] = '{
      64'd1_000_000_000, 64'd1_200_000_000, 64'd37_000_000, 64'd4_500_000_000, 64'd4_501_000_000,
      64'd36_000_000,    64'd100_000_000,   64'd1_000_000_000, 64'd0,          64'd1_000_500_000,
      64'd1_000_000_000, 64'd1_001_000_000, 64'd2_500_000_000, 64'd2_500_000_000, 64'd2_250_000_000};
   localparam int V_OK  [NV] = '{1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1};
   localparam int V_S   [NV] = '{2, 1, 6, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
   localparam int V_P   [NV] = '{3, 2, 3, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3, 4};
   localparam int V_M   [NV] = '{500, 200, 296, 375, 0, 0, 0, 0, 0, 0, 0, 0, 0, 75, 375};
   // 0:R6 1:R5 p order 2:R2 low edge 3:R2 high edge 4,5:R2 out 6,7,8:R1
   // 9,10:R3 11:R7 12:R5 m cap 13:R5 m floor 14:R4 lowest s wins
   localparam int V_REQ [NV] = '{6, 5, 2, 2, 2, 2, 1, 1, 1, 3, 3, 7, 5, 5, 4};

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_res(input string req, input int idx,
                            input int ef, input int es, input int ep, input int em);
      n_tests++;
      if (found !== ef[0] || s_out !== 3'(es) || p_out !== 3'(ep) || m_out !== 10'(em)) begin
         n_fail++;
         $display("FAIL %s case %0d: actual found/s/p/m %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                  req, idx, found, s_out, p_out, m_out, ef, es, ep, em);
      end
   endtask

   // pulse start with the given request, then wait at negedges for done
   task automatic launch(input longint unsigned fi, input longint unsigned fo);
      @(negedge clk);
      fin_hz  = fi[39:0];
      fout_hz = fo[39:0];
      start   = 1'b1;
      @(negedge clk);
      start   = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(negedge clk);
         cyc++;
      end
      check(done === 1'b1, req, "done within per-request limit", longint'(done), 1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      // R10: reset state
      repeat (3) @(negedge clk);
      check(busy === 1'b0 && done === 1'b0, "R10", "busy/done in reset", longint'({busy, done}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check({busy, done, found, s_out, p_out, m_out} === '0, "R10", "outputs after reset",
            longint'({found, s_out, p_out, m_out}), 0);

      // table of known-answer requests
      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d", V_REQ[i]);
         launch(V_FIN[i], V_FOUT[i]);
         wait_done(tag);
         check_res(tag, i, V_OK[i], V_S[i], V_P[i], V_M[i]);
         @(negedge clk);
         // R8: done lasts one cycle
         check(done === 1'b0, "R8", "done second cycle", longint'(done), 0);
      end

      // R8: busy rises the cycle after start; R9: start mid-run ignored
      launch(64'd24_000_000, 64'd1_000_000_000);
      check(busy === 1'b1, "R8", "busy after start", longint'(busy), 1);
      repeat (5) @(negedge clk);
      fin_hz  = 40'd24_000_000;
      fout_hz = 40'd1_200_000_000;
      start   = 1'b1;
      @(negedge clk);
      start   = 1'b0;
      check(busy === 1'b1, "R9", "still busy after ignored start", longint'(busy), 1);
      wait_done("R9");
      check_res("R9", 100, 1, 2, 3, 500);

      // R9: result holds while idle even as inputs move
      fout_hz = 40'd37_000_000;
      repeat (6) @(negedge clk);
      check_res("R9", 101, 1, 2, 3, 500);
      check(busy === 1'b0 && done === 1'b0, "R8", "idle after done", longint'({busy, done}), 0);

      // R7: a miss after a hit clears the previous result
      launch(64'd24_000_000, 64'd1_001_000_000);
      wait_done("R7");
      check_res("R7", 102, 0, 0, 0, 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule